// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide locations: an address location at offset 0 that latches a register index, and a data location at offset 1 that reads or writes the register picked by that index. A register access is therefore two bus cycles: the index goes to offset 0, then the value moves through offset 1.

The configuration space is locked after reset. It opens only after the entry key byte (a parameter) has been written to offset 0 on two successive address-location writes. It closes again when the exit code 0xAA is written to offset 0. While it is open, indexes below 0x30 reach global registers: the device-select register, the vendor identification bytes and a 16-bit chip identifier. Indexes from 0x30 up reach the register bank of the logical device that the device-select register currently names. Each bank holds a 16-bit I/O base and an interrupt control byte. These values are driven straight out to the device cores behind the port.

Top module: `kcp_cfg_port`

## Requirements
- R1: After reset, the port is locked, `bus_rdata` is 0x00, the index and the device-select register are 0x00, and every device's I/O base, interrupt share bit and trigger mode outputs are zero.
- R2: The port opens only when two address-location writes in succession both carry `ENTRY_KEY`. Data-location accesses and idle cycles between them do not count. Any other key value never opens it.
- R3: While locked, an address-location write whose value differs from `ENTRY_KEY`, when it follows a single key write, discards that key write. After key, other, key, the port is still locked.
- R4: While open, writing 0xAA to the address location locks the port and leaves the index unchanged. Any other value written there becomes the index.
- R5: While locked, data-location writes change no register, and data-location reads return 0xFF.
- R6: A data-location read updates `bus_rdata` on the clock edge that samples the read strobe. `bus_rdata` then holds that value until the next data-location read.
- R7: Index 0x20 reads `CHIP_ID[7:0]`, index 0x21 reads `CHIP_ID[15:8]`, index 0x23 reads 0x19 and index 0x24 reads 0x34. Writes to these indexes have no effect.
- R8: Index 0x07 is the read/write device-select register. The index stays latched across any number of data-location accesses.
- R9: For the selected device, index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of its I/O base. Device slot k (device number `DEV_FIRST`+k) drives `dev_iobase[16k+15:16k]`.
- R10: For the selected device, index 0x70 holds the interrupt share bit in bit 4 and the trigger mode in bits 6:5, where 00 means level/low and 01 means edge/high. Bits 7 and 3:0 read as 0 and ignore writes. Slot k drives `dev_irq_share[k]` and `dev_irq_mode[2k+1:2k]`.
- R11: A device-index write reaches only the bank of the selected device. When the device-select value is outside `DEV_FIRST` to `DEV_FIRST+NUM_DEV-1`, device-index writes are dropped and device-index reads return 0x00.
- R12: Unimplemented indexes, global or device, read 0x00 while the port is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Location select: 0 address location, 1 data location |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while the configuration space is unlocked |
| dev_iobase | output | 16*NUM_DEV | I/O base of each device slot |
| dev_irq_share | output | NUM_DEV | Interrupt share bit of each device slot |
| dev_irq_mode | output | 2*NUM_DEV | Trigger mode of each device slot |

## Verification
Every result is one register away from its strobe. `cfg_open`, the device outputs and `bus_rdata` all change on the edge that samples the write or read strobe. The bench drives strobes on the falling edge and samples on the next falling edge, which is half a period after the edge that commits the result. A behavioural reference model steps on the same rising edge and is compared with all outputs on every falling edge. Directed sequences that cover key breaks, exit, out-of-range device selection and the identification indexes are followed by a long pseudo-random phase over a key-heavy address mix.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] EXIT_CODE   = 8'hAA;
  localparam logic [7:0] IX_DEVSEL   = 8'h07;
  localparam logic [7:0] IX_CHIP_LO  = 8'h20;
  localparam logic [7:0] IX_CHIP_HI  = 8'h21;
  localparam logic [7:0] IX_VEND_A   = 8'h23;
  localparam logic [7:0] IX_VEND_B   = 8'h24;
  localparam logic [7:0] IX_DEV_LOW  = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] IX_IRQ      = 8'h70;
  localparam logic [7:0] VEND_A_VAL  = 8'h19;
  localparam logic [7:0] VEND_B_VAL  = 8'h34;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  // Read value of the global (non-banked) index space.
  function automatic logic [7:0] global_read(input logic [7:0] idx,
                                             input logic [7:0] devsel,
                                             input logic [15:0] chip);
    logic [7:0] v;
    case (idx)
      IX_DEVSEL:  v = devsel;
      IX_CHIP_LO: v = chip[7:0];
      IX_CHIP_HI: v = chip[15:8];
      IX_VEND_A:  v = VEND_A_VAL;
      IX_VEND_B:  v = VEND_B_VAL;
      default:    v = 8'h00;
    endcase
    return v;
  endfunction

  // True when a device-select value names an implemented device.
  function automatic logic dev_in_range(input logic [7:0] devsel,
                                        input logic [7:0] first,
                                        input logic [8:0] count);
    return ({1'b0, devsel} >= {1'b0, first}) &&
           ({1'b0, devsel} < ({1'b0, first} + count));
  endfunction

  // Byte layout of the interrupt control register.
  function automatic logic [7:0] irq_pack(input logic share,
                                          input logic [1:0] mode);
    return {1'b0, mode, share, 4'b0000};
  endfunction

endpackage

// File: rtl/kcp_key_lock.sv
module kcp_key_lock
  import kcp_pkg::*;
#(
  parameter logic [7:0] ENTRY_KEY = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       key_hit,
  output logic       exit_hit
);

  key_state_e st;

  assign key_hit  = addr_wr && (wdata == ENTRY_KEY);
  assign exit_hit = addr_wr && (wdata == EXIT_CODE) && (st == KS_OPEN);
  assign cfg_open = (st == KS_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= KS_LOCKED;
    end else if (addr_wr) begin
      case (st)
        KS_LOCKED: st <= key_hit ? KS_ARMED : KS_LOCKED;
        KS_ARMED:  st <= key_hit ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   st <= exit_hit ? KS_LOCKED : KS_OPEN;
        default:   st <= KS_LOCKED;
      endcase
    end
  end

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(key_hit));

  // R3
  broken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_ARMED && addr_wr && !key_hit) |=> !cfg_open);

  // R4
  exit_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !cfg_open);

endmodule

// File: rtl/kcp_dev_bank.sv
module kcp_dev_bank
  import kcp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_data,
  output logic [15:0] iobase,
  output logic        irq_share,
  output logic [1:0]  irq_mode
);

  logic [7:0] base_hi, base_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= 8'h00;
      base_lo   <= 8'h00;
      irq_share <= 1'b0;
      irq_mode  <= 2'b00;
    end else if (wr_en) begin
      case (idx)
        IX_BASE_HI: base_hi <= wdata;
        IX_BASE_LO: base_lo <= wdata;
        IX_IRQ: begin
          irq_share <= wdata[4];
          irq_mode  <= wdata[6:5];
        end
        default: ;
      endcase
    end
  end

  assign iobase = {base_hi, base_lo};

  always_comb begin
    case (idx)
      IX_BASE_HI: rd_data = base_hi;
      IX_BASE_LO: rd_data = base_lo;
      IX_IRQ:     rd_data = irq_pack(irq_share, irq_mode);
      default:    rd_data = 8'h00;
    endcase
  end

  // R9
  base_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_BASE_LO) |=> iobase[7:0] == $past(wdata));

  // R10
  irq_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IX_IRQ) |=>
      (irq_share == $past(wdata[4])) && (irq_mode == $past(wdata[6:5])));

  // R11
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(iobase) && $stable(irq_share) && $stable(irq_mode));

endmodule

// File: rtl/kcp_cfg_port.sv
module kcp_cfg_port
  import kcp_pkg::*;
#(
  parameter logic [7:0]  ENTRY_KEY = 8'h87,
  parameter logic [15:0] CHIP_ID   = 16'h0407,
  parameter logic [7:0]  DEV_FIRST = 8'h10,
  parameter int          NUM_DEV   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   cfg_open,
  output logic [16*NUM_DEV-1:0]  dev_iobase,
  output logic [NUM_DEV-1:0]     dev_irq_share,
  output logic [2*NUM_DEV-1:0]   dev_irq_mode
);

  localparam int         SLOT_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [8:0] DEV_CNT  = 9'(NUM_DEV);

  logic addr_wr, data_wr, data_rd;
  logic key_hit, exit_hit;
  logic [7:0] index_q, devsel_q;
  logic dev_ok, dev_space;
  logic [SLOT_W-1:0] slot;
  logic [NUM_DEV-1:0] bank_we;
  logic [7:0] bank_rd [NUM_DEV];
  logic [7:0] read_val;

  assign addr_wr = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr;
  assign data_rd = bus_rd && bus_addr;

  kcp_key_lock #(.ENTRY_KEY(ENTRY_KEY)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (addr_wr),
    .wdata    (bus_wdata),
    .cfg_open (cfg_open),
    .key_hit  (key_hit),
    .exit_hit (exit_hit)
  );

  // Index latch: loaded by address writes while open, except the exit code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= 8'h00;
    else if (addr_wr && cfg_open && !exit_hit) index_q <= bus_wdata;
  end

  // Device-select register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) devsel_q <= 8'h00;
    else if (data_wr && cfg_open && index_q == IX_DEVSEL) devsel_q <= bus_wdata;
  end

  assign dev_ok    = dev_in_range(devsel_q, DEV_FIRST, DEV_CNT);
  assign dev_space = (index_q >= IX_DEV_LOW);
  assign slot      = SLOT_W'(devsel_q - DEV_FIRST);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    assign bank_we[g] = data_wr && cfg_open && dev_space && dev_ok &&
                        (slot == SLOT_W'(g));
    kcp_dev_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bank_we[g]),
      .idx       (index_q),
      .wdata     (bus_wdata),
      .rd_data   (bank_rd[g]),
      .iobase    (dev_iobase[16*g +: 16]),
      .irq_share (dev_irq_share[g]),
      .irq_mode  (dev_irq_mode[2*g +: 2])
    );
  end

  always_comb begin
    if (!cfg_open)      read_val = LOCKED_READ;
    else if (!dev_space) read_val = global_read(index_q, devsel_q, CHIP_ID);
    else if (dev_ok)    read_val = bank_rd[slot];
    else                read_val = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else if (data_rd) bus_rdata <= read_val;
  end

  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && data_rd) |=> bus_rdata == LOCKED_READ);

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && data_wr) |=>
      $stable(dev_iobase) && $stable(dev_irq_share) && $stable(dev_irq_mode));

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(bus_rdata));

  // R11
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R8
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(index_q));

endmodule

// File: tb/tb_kcp_cfg_port.sv
`timescale 1ns/1ps
module tb_kcp_cfg_port;

  localparam int ND = 7;
  localparam logic [7:0] KEY = 8'h87;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_open;
  logic [16*ND-1:0] dev_iobase;
  logic [ND-1:0] dev_irq_share;
  logic [2*ND-1:0] dev_irq_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kcp_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .dev_iobase(dev_iobase),
    .dev_irq_share(dev_irq_share), .dev_irq_mode(dev_irq_mode)
  );

  // Behavioural reference model
  int         m_keys;      // consecutive key writes seen while locked
  bit         m_open;
  logic [7:0] m_idx, m_sel, m_rd;
  logic [15:0] m_base [ND];
  logic        m_sh [ND];
  logic [1:0]  m_md [ND];

  function automatic int sel_slot(input logic [7:0] s);
    if (s >= 8'h10 && s <= 8'h16) return int'(s) - 16;
    return -1;
  endfunction

  function automatic logic [7:0] model_read();
    int k;
    if (!m_open) return 8'hFF;
    if (m_idx < 8'h30) begin
      if (m_idx == 8'h07) return m_sel;
      if (m_idx == 8'h20) return 8'h07;
      if (m_idx == 8'h21) return 8'h04;
      if (m_idx == 8'h23) return 8'h19;
      if (m_idx == 8'h24) return 8'h34;
      return 8'h00;
    end
    k = sel_slot(m_sel);
    if (k < 0) return 8'h00;
    if (m_idx == 8'h60) return m_base[k][15:8];
    if (m_idx == 8'h61) return m_base[k][7:0];
    if (m_idx == 8'h70) return {1'b0, m_md[k], m_sh[k], 4'h0};
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    int k;
    if (!rst_n) begin
      m_keys = 0; m_open = 0; m_idx = 0; m_sel = 0; m_rd = 0;
      for (int i = 0; i < ND; i++) begin m_base[i] = 0; m_sh[i] = 0; m_md[i] = 0; end
    end else begin
      if (bus_rd && bus_addr) m_rd = model_read();
      if (bus_wr && bus_addr && m_open) begin
        k = sel_slot(m_sel);
        if (m_idx == 8'h07) m_sel = bus_wdata;
        else if (m_idx >= 8'h30 && k >= 0) begin
          if (m_idx == 8'h60) m_base[k][15:8] = bus_wdata;
          if (m_idx == 8'h61) m_base[k][7:0] = bus_wdata;
          if (m_idx == 8'h70) begin m_sh[k] = bus_wdata[4]; m_md[k] = bus_wdata[6:5]; end
        end
      end
      if (bus_wr && !bus_addr) begin
        if (m_open) begin
          if (bus_wdata == 8'hAA) begin m_open = 0; m_keys = 0; end
          else m_idx = bus_wdata;
        end else if (bus_wdata == KEY) begin
          m_keys++;
          if (m_keys == 2) begin m_open = 1; m_keys = 0; end
        end else m_keys = 0;
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cfg_open !== m_open) begin
        fails++; $display("FAIL R2 cfg_open act=%0b exp=%0b", cfg_open, m_open);
      end
      if (bus_rdata !== m_rd) begin
        fails++; $display("FAIL R6 bus_rdata act=%h exp=%h", bus_rdata, m_rd);
      end
      for (int i = 0; i < ND; i++) begin
        if (dev_iobase[16*i +: 16] !== m_base[i]) begin
          fails++; $display("FAIL R9 slot%0d iobase act=%h exp=%h", i, dev_iobase[16*i +: 16], m_base[i]);
        end
        if (dev_irq_share[i] !== m_sh[i] || dev_irq_mode[2*i +: 2] !== m_md[i]) begin
          fails++; $display("FAIL R10 slot%0d irq act=%b/%b exp=%b/%b", i,
                            dev_irq_share[i], dev_irq_mode[2*i +: 2], m_sh[i], m_md[i]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); bus_addr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] v);
    wr(1'b0, ix); rd(v);
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] v);
    wr(1'b0, ix); wr(1'b1, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 open", 16'(cfg_open), 16'h0);
    chk("R1 rdata", 16'(bus_rdata), 16'h00);
    chk("R1 iobase slot0", dev_iobase[15:0], 16'h0);
    chk("R1 irq", 16'({dev_irq_share, dev_irq_mode}), 16'h0);

    // R5 locked read and write
    rd(v); chk("R5 locked read", 16'(v), 16'hFF);
    wr(1'b1, 8'h5A);
    chk("R5 locked write ignored", dev_iobase[15:0], 16'h0);

    // R2 wrong key never opens
    wr(1'b0, 8'h77); wr(1'b0, 8'h77);
    chk("R2 wrong key", 16'(cfg_open), 16'h0);
    // R3 broken sequence
    wr(1'b0, KEY); wr(1'b0, 8'h11); wr(1'b0, KEY);
    chk("R3 broken seq", 16'(cfg_open), 16'h0);
    // R2 data access between keys does not break
    rd(v); wr(1'b0, KEY);
    chk("R2 open", 16'(cfg_open), 16'h1);

    // R7 identification
    reg_rd(8'h20, v); chk("R7 chip lo", 16'(v), 16'h07);
    reg_rd(8'h21, v); chk("R7 chip hi", 16'(v), 16'h04);
    reg_rd(8'h23, v); chk("R7 vend a", 16'(v), 16'h19);
    reg_rd(8'h24, v); chk("R7 vend b", 16'(v), 16'h34);
    reg_wr(8'h23, 8'h55); rd(v); chk("R7 ro", 16'(v), 16'h19);
    // R12 unimplemented global
    reg_rd(8'h2F, v); chk("R12 global", 16'(v), 16'h00);

    // R8 device select
    reg_wr(8'h07, 8'h12); rd(v); chk("R8 devsel", 16'(v), 16'h12);
    // R9 base
    reg_wr(8'h60, 8'h03); reg_wr(8'h61, 8'hF8);
    chk("R9 iobase slot2", dev_iobase[32 +: 16], 16'h03F8);
    rd(v); chk("R8 index latched", 16'(v), 16'hF8);
    rd(v); chk("R8 index latched again", 16'(v), 16'hF8);
    reg_rd(8'h60, v); chk("R9 base hi", 16'(v), 16'h03);
    reg_rd(8'h45, v); chk("R12 device", 16'(v), 16'h00);

    // R10 irq control
    reg_wr(8'h07, 8'h15); reg_wr(8'h70, 8'hFF);
    rd(v); chk("R10 reserved bits", 16'(v), 16'h70);
    chk("R10 share", 16'(dev_irq_share[5]), 16'h1);
    reg_wr(8'h70, 8'h30);
    chk("R10 edge mode", 16'(dev_irq_mode[10 +: 2]), 16'h1);
    rd(v); chk("R10 readback", 16'(v), 16'h30);
    // R11 bank isolation
    chk("R11 slot5 base", dev_iobase[80 +: 16], 16'h0);
    chk("R11 slot2 kept", dev_iobase[32 +: 16], 16'h03F8);
    chk("R11 slot2 irq", 16'(dev_irq_share[2]), 16'h0);
    // R11 out-of-range select
    reg_wr(8'h07, 8'h05); reg_wr(8'h60, 8'hAB);
    rd(v); chk("R11 oor read", 16'(v), 16'h00);
    chk("R11 oor write", 16'(dev_iobase[15:0]), 16'h0);

    // R4 exit
    reg_wr(8'h07, 8'h12); wr(1'b0, 8'h60);
    wr(1'b0, 8'hAA);
    chk("R4 exit", 16'(cfg_open), 16'h0);
    rd(v); chk("R5 locked after exit", 16'(v), 16'hFF);
    wr(1'b1, 8'h99);
    chk("R5 ignored after exit", dev_iobase[32 +: 16], 16'h03F8);
    wr(1'b0, KEY); wr(1'b0, KEY);
    rd(v); chk("R4 index kept", 16'(v), 16'h03);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset open", 16'(cfg_open), 16'h0);
    chk("R1 reset base", dev_iobase[32 +: 16], 16'h0);

    // Pseudo-random phase checked by the model
    for (int n = 0; n < 6000; n++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 11));
      bus_wr = 1'b0; bus_rd = 1'b0;
      case (r)
        0, 1, 2: begin bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = KEY; end
        3: begin bus_addr = 1'b0; bus_wr = 1'b1;
             bus_wdata = ($urandom_range(0, 3) == 0) ? 8'hAA : 8'($urandom); end
        4: begin bus_addr = 1'b0; bus_wr = 1'b1;
             case ($urandom_range(0, 4))
               0: bus_wdata = 8'h07; 1: bus_wdata = 8'h60; 2: bus_wdata = 8'h61;
               3: bus_wdata = 8'h70; default: bus_wdata = 8'h20;
             endcase
           end
        5, 6: begin bus_addr = 1'b1; bus_wr = 1'b1;
             bus_wdata = (dut.u_lock.cfg_open === 1'bx) ? 8'h00 : 8'($urandom); end
        7: begin bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'(8'h0F + $urandom_range(0, 8)); end
        8, 9: begin bus_addr = 1'b1; bus_rd = 1'b1; end
        default: ;
      endcase
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule